// File: doc/BRIEF.md
# Synthesiser Loop Digital Core

This block holds the digital half of a frequency synthesiser loop. It runs on one system clock and takes two single-cycle strobes: one for each edge of the reference oscillator and one for each edge of the prescaled RF signal. A fixed reference divider turns the reference strobes into a comparison event. A programmable 15-bit divider turns the RF strobes into a divided event. A phase-frequency detector compares the two events and drives pump-up and pump-down requests to an external analog charge pump.

A lock monitor watches the width of each detector pulse and raises a lock flag after a run of narrow pulses. Four control bits adjust the loop:
- one silences the pump requests;
- one routes the two comparator events onto test pins;
- one selects the high pump current;
- one switches off the varactor drive amplifier.

The synthesised frequency is the divide ratio times eight times the comparison rate, because the RF input comes through an external divide-by-8 prescaler. With a 4 MHz reference, the comparison rate is 7.8125 kHz.

Top module: `synth_loop_core`

## Requirements
- R1: The comparison event occurs once per REF_DIV (default 512) reference strobes. With the test mode on, `tst_p6` pulses once per event.
- R2: The divided event occurs once per N RF strobes, where N is `ratio`. With the test mode on, `tst_p7` pulses once per event.
- R3: A `ratio` of 0 or 1 divides by 2.
- R4: When the divided event lags the comparison event, only `pump_up` goes high. When it leads, only `pump_dn` goes high. The two are never high together.
- R5: While `t0`=1, `pump_up` and `pump_dn` stay 0.
- R6: While `t1`=1, each comparison event and each divided event appears one cycle later as a one-cycle pulse, on `tst_p6` and `tst_p7` respectively. While `t1`=0, both outputs stay 0.
- R7: `cur_hi` follows `cp` and `drv_off` follows `os` without delay. A value of 1 means high current and amplifier off.
- R8: `locked` rises when the detector completes LOCK_CNT (default 4) consecutive comparisons whose pulse lasts no more than LOCK_TOL (default 8) clocks. It does not rise before the last of these comparisons.
- R9: A detector pulse longer than LOCK_TOL clocks clears `locked`.
- R10: After reset, `pump_up`, `pump_dn`, `locked`, `tst_p6` and `tst_p7` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ref_en | input | 1 | Reference edge strobe |
| rf_en | input | 1 | Prescaled RF edge strobe |
| ratio | input | 15 | Programmable divide ratio |
| t0 | input | 1 | Pump silence |
| t1 | input | 1 | Test routing enable |
| cp | input | 1 | High pump current select |
| os | input | 1 | Drive amplifier off |
| pump_up | output | 1 | Raise-frequency request |
| pump_dn | output | 1 | Lower-frequency request |
| cur_hi | output | 1 | Pump current select |
| drv_off | output | 1 | Drive amplifier disable |
| locked | output | 1 | Phase lock flag |
| tst_p6 | output | 1 | Comparison event test output |
| tst_p7 | output | 1 | Divided event test output |

## Verification
The bench checks the lock count exactly. It samples after three comparisons and again after four, so a monitor that counts one too few or one too many fails. It checks the ratio values 0 and 1 against an exact divide-by-2 pulse count; a design without the clamp would stall or run at the wrong rate. Two mismatched ratios check that a slow divider gives only up pulses and a fast one only down pulses, which catches a swapped detector. A retune after lock must drop the flag, which catches a monitor that ignores wide pulses.

// File: rtl/synth_loop_core.sv
module synth_loop_core #(
  parameter int REF_DIV  = 512,
  parameter int RATIO_W  = 15,
  parameter int LOCK_TOL = 8,
  parameter int LOCK_CNT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_en,
  input  logic               rf_en,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               t0,
  input  logic               t1,
  input  logic               cp,
  input  logic               os,
  output logic               pump_up,
  output logic               pump_dn,
  output logic               cur_hi,
  output logic               drv_off,
  output logic               locked,
  output logic               tst_p6,
  output logic               tst_p7
);
  localparam int RC_W = $clog2(REF_DIV);
  localparam int PW_W = $clog2(LOCK_TOL + 2) + 1;
  localparam int LC_W = $clog2(LOCK_CNT + 1);
  localparam logic [RC_W-1:0] RC_MAX = RC_W'(REF_DIV - 1);
  localparam logic [PW_W-1:0] PW_TOL = PW_W'(LOCK_TOL);
  localparam logic [LC_W-1:0] LC_TOP = LC_W'(LOCK_CNT - 1);

  logic [RC_W-1:0]    ref_cnt;
  logic [RATIO_W-1:0] div_cnt;
  logic [RATIO_W-1:0] ratio_eff;
  logic               comp_ev, div_ev;
  logic               up_q, dn_q, up_n, dn_n, pair;
  logic [PW_W-1:0]    pulse_w, w_now;
  logic [LC_W-1:0]    good_cnt;
  logic               wide;

  assign ratio_eff = (ratio < RATIO_W'(2)) ? RATIO_W'(2) : ratio;
  assign comp_ev   = ref_en && (ref_cnt == RC_MAX);
  assign div_ev    = rf_en && (div_cnt >= ratio_eff - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_cnt <= '0;
    else if (ref_en) ref_cnt <= (ref_cnt == RC_MAX) ? '0 : ref_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else if (rf_en) div_cnt <= div_ev ? '0 : div_cnt + 1'b1;
  end

  assign up_n = up_q | comp_ev;
  assign dn_n = dn_q | div_ev;
  assign pair = up_n & dn_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_n & ~pair;
      dn_q <= dn_n & ~pair;
    end
  end

  assign pump_up = up_q & ~t0;
  assign pump_dn = dn_q & ~t0;
  assign cur_hi  = cp;
  assign drv_off = os;

  assign w_now = pulse_w + PW_W'(up_q | dn_q);
  assign wide  = w_now > PW_TOL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_w <= '0;
    else if (pair) pulse_w <= '0;
    else if ((up_q | dn_q) && !wide) pulse_w <= w_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (wide) begin
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (pair) begin
      if (good_cnt >= LC_TOP) locked <= 1'b1;
      else good_cnt <= good_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tst_p6 <= 1'b0;
      tst_p7 <= 1'b0;
    end else begin
      tst_p6 <= t1 & comp_ev;
      tst_p7 <= t1 & div_ev;
    end
  end

  assert_pump_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));
  assert_t0_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    t0 |-> (!pump_up && !pump_dn));
  assert_test_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !t1 |=> (!tst_p6 && !tst_p7));
  assert_wide_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((up_q || dn_q) && pulse_w >= PW_TOL) |=> !locked);
endmodule

// File: tb/synth_loop_core_tb_top.sv
`timescale 1ns/1ps
module synth_loop_core_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, ref_en = 1'b1, rf_en = 1'b0;
  logic [14:0] ratio = 15'd256;
  logic t0 = 1'b0, t1 = 1'b0, cp = 1'b0, os = 1'b0;
  logic pump_up, pump_dn, cur_hi, drv_off, locked, tst_p6, tst_p7;
  int total = 0, bad = 0, per = 2, rf_c = 0;

  always #2.5 clk = ~clk;

  synth_loop_core dut_i (.clk(clk), .rst_n(rst_n), .ref_en(ref_en), .rf_en(rf_en),
    .ratio(ratio), .t0(t0), .t1(t1), .cp(cp), .os(os), .pump_up(pump_up),
    .pump_dn(pump_dn), .cur_hi(cur_hi), .drv_off(drv_off), .locked(locked),
    .tst_p6(tst_p6), .tst_p7(tst_p7));

  initial forever begin
    @(negedge clk);
    if (!rst_n) begin rf_c = 0; rf_en = 1'b0; end
    else begin
      rf_en = (rf_c == 0);
      rf_c = (rf_c + 1 >= per) ? 0 : rf_c + 1;
    end
  end

  localparam int NV = 5;
  localparam int V_RATIO [NV] = '{256, 128, 512, 200, 300};
  localparam int V_PER   [NV] = '{2, 4, 1, 2, 2};
  localparam int V_LOCK  [NV] = '{1, 1, 1, 0, 0};
  localparam int V_MODE  [NV] = '{0, 0, 0, 1, 2};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic count(input int n, output int uc, output int dc, output int p6, output int p7);
    uc = 0; dc = 0; p6 = 0; p7 = 0;
    repeat (n) begin
      @(negedge clk);
      uc += int'(pump_up); dc += int'(pump_dn);
      p6 += int'(tst_p6); p7 += int'(tst_p7);
    end
  endtask

  initial begin
    #(190000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int uc, dc, p6, p7;
    @(negedge clk); @(negedge clk);
    chk("R10 pump_up", int'(pump_up), 0);
    chk("R10 pump_dn", int'(pump_dn), 0);
    chk("R10 locked", int'(locked), 0);
    chk("R10 test outs", int'(tst_p6 | tst_p7), 0);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      ratio = 15'(V_RATIO[i]); per = V_PER[i];
      do_reset();
      repeat (10 * 512) @(negedge clk);
      chk($sformatf("R8 vector %0d lock", i), int'(locked), V_LOCK[i]);
      count(2048, uc, dc, p6, p7);
      if (V_MODE[i] == 1) begin
        chk("R4 lead up", uc, 0); chk("R4 lead dn seen", int'(dc > 0), 1);
      end else if (V_MODE[i] == 2) begin
        chk("R4 lag dn", dc, 0); chk("R4 lag up seen", int'(uc > 0), 1);
      end else begin
        chk("R4 locked pulses narrow", int'(uc + dc <= 4 * 8), 1);
      end
    end

    ratio = 15'd256; per = 2; do_reset();
    repeat (1792) @(negedge clk);
    chk("R8 not locked after three", int'(locked), 0);
    repeat (512) @(negedge clk);
    chk("R8 locked after four", int'(locked), 1);
    ratio = 15'd300;
    repeat (3 * 512) @(negedge clk);
    chk("R9 retune unlocks", int'(locked), 0);

    t0 = 1'b1; do_reset();
    count(4096, uc, dc, p6, p7);
    chk("R5 up silenced", uc, 0);
    chk("R5 dn silenced", dc, 0);
    chk("R6 p6 off", p6, 0);
    chk("R6 p7 off", p7, 0);
    t0 = 1'b0;

    t1 = 1'b1; ratio = 15'd256; per = 2; do_reset();
    repeat (20) @(negedge clk);
    count(2048, uc, dc, p6, p7);
    chk("R1 comparison pulses", p6, 4);
    chk("R2 divided pulses", p7, 4);

    per = 1; ratio = 15'd0;
    repeat (20) @(negedge clk);
    count(100, uc, dc, p6, p7);
    chk("R3 ratio 0", p7, 50);
    ratio = 15'd1;
    repeat (20) @(negedge clk);
    count(100, uc, dc, p6, p7);
    chk("R3 ratio 1", p7, 50);
    ratio = 15'd3;
    repeat (20) @(negedge clk);
    count(99, uc, dc, p6, p7);
    chk("R2 ratio 3", p7, 33);
    t1 = 1'b0;

    cp = 1'b1; os = 1'b0; #1;
    chk("R7 cur_hi high", int'(cur_hi), 1);
    chk("R7 drv_off low", int'(drv_off), 0);
    cp = 1'b0; os = 1'b1; #1;
    chk("R7 cur_hi low", int'(cur_hi), 0);
    chk("R7 drv_off high", int'(drv_off), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule